// File: doc/BRIEF.md
# Framed PRBS Lock Monitor

This block watches a received T1 or E1 line bit stream without pause. It checks whether the payload bits of each frame carry one of two pseudorandom test sequences. Two checkers run side by side, one per sequence, and each has its own lock flag. The block takes one serial bit per strobe, a marker on the first bit of each frame, and a line-mode select. The framing overhead positions are skipped and do not count toward either sequence.

Each checker starts in a search state. In that state it loads its history register from the received payload bits and compares every new bit with the bit that the history predicts. A run of error-free predictions declares lock. Once locked, the checker produces its own reference sequence and counts mismatches in each frame. It keeps lock while the error count stays inside a fixed budget. When the budget is exceeded, the checker drops lock and goes back to searching.

Top module: `prbs_lock_monitor`

## Requirements
- R1: With `mode_e1_i` = 0 (T1), a frame has 193 bit positions. Position 0 is the bit sampled with `frame_start_i` = 1 and is framing overhead. It is skipped. The other 192 positions are pattern bits.
- R2: With `mode_e1_i` = 1 (E1), a frame has 256 bit positions. Positions 0 to 7 are skipped. The other 248 positions are pattern bits, and this includes positions 128 to 135, which are treated as ordinary pattern bits.
- R3: `lock_prbs15_o` tracks the sequence b(n) = b(n-15) XOR b(n-14). `lock_qrss_o` tracks the raw sequence r(n) = r(n-17) XOR r(n-20), with output q(n) = r(n) OR (r(n-1) to r(n-14) all zero). The two checkers run independently.
- R4: In search, the lock flag rises on the clock edge that samples the 256th consecutive pattern bit that matches the prediction. It reads 1 from the next cycle on.
- R5: In search, every received pattern bit is shifted into the checker's history. A mismatching bit clears the run count to zero.
- R6: Once locked, the checker runs its own sequence and is not disturbed by received errors. Up to 32 mismatches within one frame keep lock. The 33rd mismatch in the same frame clears the flag on the edge that samples it, and the checker returns to search with a run count of zero.
- R7: The error count of a locked checker restarts at each frame start. Errors in different frames never add up.
- R8: A cycle with `rx_vld_i` = 0 changes nothing, and overhead bits do not alter either checker. The lock flags stay unchanged across such bits.
- R9: After reset, both flags are 0, both checkers are in search with an all-zero history, and the frame position is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_bit_i | input | 1 | Received serial data bit |
| rx_vld_i | input | 1 | Qualifies `rx_bit_i` for this cycle |
| frame_start_i | input | 1 | Marks the first bit of a frame (valid only with `rx_vld_i`) |
| mode_e1_i | input | 1 | 0 = T1 framing, 1 = E1 framing |
| lock_prbs15_o | output | 1 | Lock flag of the 15-stage sequence checker |
| lock_qrss_o | output | 1 | Lock flag of the zero-limited 20-stage sequence checker |

## Verification
The bench drives whole frames in both line modes and compares the lock flags on every bit against a bench-side model. It also makes fixed checks at chosen points. Errors are placed exactly 32 and 33 to a frame, and also split across a frame boundary. A budget off by one would then either drop lock at 32 errors or keep it at 33. A counter that is not cleared at frame start would drop lock on the split errors. A single search error near bit 200 shows whether the run count really restarts: a design that failed to restart it would lock one frame too early. The E1 runs check that slot 16 counts as pattern. The T1 runs, with random framing bits and idle gaps, catch a design that shifts overhead or idle bits into its history.

// File: rtl/prbsmon_pkg.sv
package prbsmon_pkg;

    localparam int T1_FRAME_LEN  = 193;
    localparam int E1_FRAME_LEN  = 256;
    localparam int E1_OVH_LEN    = 8;
    localparam int LOCK_RUN_LEN  = 256;
    localparam int FRAME_ERR_MAX = 32;

    typedef enum logic {
        MODE_T1 = 1'b0,
        MODE_E1 = 1'b1
    } line_mode_e;

endpackage

// File: rtl/prbsmon_slot_tracker.sv
module prbsmon_slot_tracker
    import prbsmon_pkg::*;
#(
    parameter int T1_LEN  = T1_FRAME_LEN,
    parameter int E1_LEN  = E1_FRAME_LEN,
    parameter int E1_OVH  = E1_OVH_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld_i,
    input  logic frm_i,
    input  logic mode_i,
    output logic pay_o,
    output logic frm_o
);

    localparam int MAX_LEN = (E1_LEN > T1_LEN) ? E1_LEN : T1_LEN;
    localparam int POS_W   = $clog2(MAX_LEN);

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } slot_st_t;

    slot_st_t st_d, st_q;
    logic [POS_W-1:0] cur_pos;
    logic             last_pos;
    logic             ovh;

    always_comb begin
        st_d     = st_q;
        cur_pos  = frm_i ? '0 : st_q.pos;
        if (mode_i == MODE_E1) begin
            last_pos = (cur_pos == POS_W'(E1_LEN - 1));
            ovh      = (cur_pos < POS_W'(E1_OVH));
        end else begin
            last_pos = (cur_pos == POS_W'(T1_LEN - 1));
            ovh      = (cur_pos == '0);
        end
        if (vld_i) begin
            st_d.pos = last_pos ? '0 : cur_pos + 1'b1;
        end
        pay_o = vld_i & ~ovh;
        frm_o = vld_i & frm_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R1: the bit carrying the frame marker is never a pattern bit
    p_frame_bit_skipped_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frm_o |-> !pay_o);

    // R2: in E1 the bit right after the marker still belongs to slot 0
    p_ts0_skipped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_o && mode_i == MODE_E1) ##1 (mode_i == MODE_E1) |-> !pay_o);

endmodule

// File: rtl/prbsmon_seq_checker.sv
module prbsmon_seq_checker
    import prbsmon_pkg::*;
#(
    parameter int HIST_W   = 15,
    parameter int TAP_A    = 15,
    parameter int TAP_B    = 14,
    parameter int ZS_LEN   = 0,
    parameter int LOCK_RUN = LOCK_RUN_LEN,
    parameter int ERR_MAX  = FRAME_ERR_MAX
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    input  logic pay_i,
    input  logic frm_i,
    output logic lock_o
);

    localparam int RUN_W = $clog2(LOCK_RUN);
    localparam int ERR_W = $clog2(ERR_MAX + 2);

    typedef struct packed {
        logic [HIST_W-1:0] hist;
        logic [RUN_W-1:0]  run;
        logic [ERR_W-1:0]  err;
        logic              lock;
    } chk_st_t;

    chk_st_t st_d, st_q;
    logic    raw_pred;
    logic    force_one;
    logic    exp_bit;
    logic    miss;

    generate
        if (ZS_LEN > 0) begin : g_zero_limit
            assign force_one = ~|st_q.hist[ZS_LEN-1:0];
        end else begin : g_plain
            assign force_one = 1'b0;
        end
    endgenerate

    assign raw_pred = st_q.hist[TAP_A-1] ^ st_q.hist[TAP_B-1];
    assign exp_bit  = raw_pred | force_one;
    assign miss     = bit_i ^ exp_bit;

    always_comb begin
        st_d = st_q;
        if (frm_i) begin
            st_d.err = '0;
        end
        if (pay_i) begin
            if (st_q.lock) begin
                st_d.hist = {st_q.hist[HIST_W-2:0], raw_pred};
                if (miss) begin
                    if (st_q.err == ERR_W'(ERR_MAX)) begin
                        st_d.lock = 1'b0;
                        st_d.run  = '0;
                        st_d.err  = '0;
                    end else begin
                        st_d.err = st_q.err + 1'b1;
                    end
                end
            end else begin
                st_d.hist = {st_q.hist[HIST_W-2:0], bit_i};
                if (miss) begin
                    st_d.run = '0;
                end else if (st_q.run == RUN_W'(LOCK_RUN - 1)) begin
                    st_d.lock = 1'b1;
                    st_d.run  = '0;
                    st_d.err  = '0;
                end else begin
                    st_d.run = st_q.run + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_o = st_q.lock;

    // R4: lock only follows a full matching run
    p_lock_after_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.lock) |-> $past(st_q.run == RUN_W'(LOCK_RUN - 1) && pay_i && !miss));

    // R6: while locked the frame error count never passes the budget
    p_err_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |-> (st_q.err <= ERR_W'(ERR_MAX)));

    // R6: lock falls only on the error beyond the budget
    p_drop_on_excess_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.lock) |-> $past(st_q.err == ERR_W'(ERR_MAX) && pay_i && miss));

    // R7: a frame marker clears the error count
    p_err_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_i && !pay_i) |=> (st_q.err == '0));

endmodule

// File: rtl/prbs_lock_monitor.sv
module prbs_lock_monitor
    import prbsmon_pkg::*;
#(
    parameter int T1_LEN   = T1_FRAME_LEN,
    parameter int E1_LEN   = E1_FRAME_LEN,
    parameter int E1_OVH   = E1_OVH_LEN,
    parameter int LOCK_RUN = LOCK_RUN_LEN,
    parameter int ERR_MAX  = FRAME_ERR_MAX
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit_i,
    input  logic rx_vld_i,
    input  logic frame_start_i,
    input  logic mode_e1_i,
    output logic lock_prbs15_o,
    output logic lock_qrss_o
);

    localparam int N_CHK = 2;
    localparam int CHK_HIST [N_CHK] = '{15, 20};
    localparam int CHK_TAPA [N_CHK] = '{15, 20};
    localparam int CHK_TAPB [N_CHK] = '{14, 17};
    localparam int CHK_ZS   [N_CHK] = '{0, 14};

    logic             pay_w;
    logic             frm_w;
    logic [N_CHK-1:0] lock_w;

    prbsmon_slot_tracker #(
        .T1_LEN (T1_LEN),
        .E1_LEN (E1_LEN),
        .E1_OVH (E1_OVH)
    ) u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (rx_vld_i),
        .frm_i  (frame_start_i),
        .mode_i (mode_e1_i),
        .pay_o  (pay_w),
        .frm_o  (frm_w)
    );

    generate
        for (genvar g = 0; g < N_CHK; g++) begin : g_chk
            prbsmon_seq_checker #(
                .HIST_W   (CHK_HIST[g]),
                .TAP_A    (CHK_TAPA[g]),
                .TAP_B    (CHK_TAPB[g]),
                .ZS_LEN   (CHK_ZS[g]),
                .LOCK_RUN (LOCK_RUN),
                .ERR_MAX  (ERR_MAX)
            ) u_chk (
                .clk    (clk),
                .rst_n  (rst_n),
                .bit_i  (rx_bit_i),
                .pay_i  (pay_w),
                .frm_i  (frm_w),
                .lock_o (lock_w[g])
            );
        end
    endgenerate

    assign lock_prbs15_o = lock_w[0];
    assign lock_qrss_o   = lock_w[1];

    // R8: flags move only on a valid pattern bit
    p_idle_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pay_w |=> $stable(lock_w));

endmodule

// File: tb/prbs_lock_monitor_tb.sv
`timescale 1ns/1ps
module prbs_lock_monitor_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_bit_i = 1'b0;
    logic rx_vld_i = 1'b0;
    logic frame_start_i = 1'b0;
    logic mode_e1_i = 1'b0;
    logic lock_prbs15_o;
    logic lock_qrss_o;

    always #2.5 clk = ~clk;

    prbs_lock_monitor u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_bit_i      (rx_bit_i),
        .rx_vld_i      (rx_vld_i),
        .frame_start_i (frame_start_i),
        .mode_e1_i     (mode_e1_i),
        .lock_prbs15_o (lock_prbs15_o),
        .lock_qrss_o   (lock_qrss_o)
    );

    int    total = 0;
    int    bad = 0;
    string cur_tag = "R9";

    // bench model state
    logic [19:0] m_hist [2];
    int          m_run  [2];
    int          m_err  [2];
    bit          m_lock [2];
    int          m_pos;
    // stimulus generators
    logic [14:0] g15 = 15'h1ACE;
    logic [19:0] gq  = 20'hB5A3D;
    int          sel = 0;

    function automatic logic gen_bit();
        logic r;
        if (sel == 0) begin
            r   = g15[14] ^ g15[13];
            g15 = {g15[13:0], r};
            return r;
        end else begin
            logic q;
            r  = gq[19] ^ gq[16];
            q  = r | (gq[13:0] == 14'd0);
            gq = {gq[18:0], r};
            return q;
        end
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            m_hist[k] = '0; m_run[k] = 0; m_err[k] = 0; m_lock[k] = 1'b0;
        end
        m_pos = 0;
    endtask

    task automatic model_bit(input logic b, input logic frm, input logic vld);
        int  cur;
        int  flen;
        bit  pay;
        if (!vld) return;
        cur   = frm ? 0 : m_pos;
        flen  = mode_e1_i ? 256 : 193;
        m_pos = (cur == flen - 1) ? 0 : cur + 1;
        pay   = mode_e1_i ? (cur >= 8) : (cur != 0);
        for (int k = 0; k < 2; k++) begin
            int   ta;
            int   tb;
            logic rp;
            logic ex;
            ta = (k == 1) ? 20 : 15;
            tb = (k == 1) ? 17 : 14;
            if (frm) m_err[k] = 0;
            if (pay) begin
                rp = m_hist[k][ta-1] ^ m_hist[k][tb-1];
                ex = rp | ((k == 1) && (m_hist[k][13:0] == 14'd0));
                if (m_lock[k]) begin
                    m_hist[k] = {m_hist[k][18:0], rp};
                    if (b != ex) begin
                        if (m_err[k] == 32) begin
                            m_lock[k] = 1'b0; m_run[k] = 0; m_err[k] = 0;
                        end else begin
                            m_err[k]++;
                        end
                    end
                end else begin
                    m_hist[k] = {m_hist[k][18:0], b};
                    if (b != ex) m_run[k] = 0;
                    else if (m_run[k] == 255) begin
                        m_lock[k] = 1'b1; m_run[k] = 0; m_err[k] = 0;
                    end else m_run[k]++;
                end
            end
        end
    endtask

    task automatic check1(input string tag, input string what, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s got=%0d exp=%0d", tag, what, got, exp);
        end
    endtask

    task automatic compare_model();
        check1(cur_tag, "lock_prbs15 vs model", lock_prbs15_o, m_lock[0]);
        check1(cur_tag, "lock_qrss vs model", lock_qrss_o, m_lock[1]);
    endtask

    task automatic step(input logic b, input logic frm, input logic vld);
        @(negedge clk);
        compare_model();
        rx_bit_i      = b;
        frame_start_i = frm;
        rx_vld_i      = vld;
        model_bit(b, frm, vld);
    endtask

    task automatic settle();
        @(negedge clk);
        rx_vld_i = 1'b0;
        frame_start_i = 1'b0;
        @(negedge clk);
        compare_model();
    endtask

    // first_n: flip the first n pattern bits; last_n: flip the last n pattern bits
    task automatic send_frame(input int first_n, input int last_n, input bit gaps);
        int flen;
        int npay;
        int pidx;
        flen = mode_e1_i ? 256 : 193;
        npay = mode_e1_i ? 248 : 192;
        pidx = 0;
        for (int pos = 0; pos < flen; pos++) begin
            logic b;
            bit   pay;
            if (gaps && (pos % 37 == 20)) step(1'($urandom), 1'b0, 1'b0);
            pay = mode_e1_i ? (pos >= 8) : (pos != 0);
            if (pay) begin
                b = gen_bit();
                if (pidx < first_n || pidx >= npay - last_n) b = ~b;
                pidx++;
            end else begin
                b = 1'($urandom);
            end
            step(b, pos == 0, 1'b1);
        end
    endtask

    task automatic do_reset(input logic e1);
        @(negedge clk);
        rst_n = 1'b0;
        rx_vld_i = 1'b0;
        frame_start_i = 1'b0;
        mode_e1_i = e1;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #1ms;
        total++;
        bad++;
        $display("FAIL watchdog expired got=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R9: reset state
        do_reset(1'b0);
        @(negedge clk);
        check1("R9", "lock_prbs15 after reset", lock_prbs15_o, 1'b0);
        check1("R9", "lock_qrss after reset", lock_qrss_o, 1'b0);

        // R1 R3 R4: T1 with the 15-stage sequence, random framing bits, idle gaps (R8)
        cur_tag = "R1";
        sel = 0;
        repeat (2) send_frame(0, 0, 1'b1);
        settle();
        check1("R4", "prbs15 locked after 384 good bits", lock_prbs15_o, 1'b1);
        check1("R3", "qrss stays unlocked on other sequence", lock_qrss_o, 1'b0);

        // R6: 32 errors in one frame keep lock, 33 drop it
        cur_tag = "R6";
        send_frame(32, 0, 1'b0);
        settle();
        check1("R6", "lock kept at 32 errors", lock_prbs15_o, 1'b1);
        send_frame(0, 0, 1'b1);
        send_frame(33, 0, 1'b0);
        settle();
        check1("R6", "lock lost at 33 errors", lock_prbs15_o, 1'b0);

        // R5: relock after loss, then a single search error delays it
        cur_tag = "R5";
        do_reset(1'b0);
        sel = 0;
        send_frame(0, 0, 1'b0);
        send_frame(0, 0, 1'b0);
        settle();
        check1("R4", "prbs15 locked within two T1 frames", lock_prbs15_o, 1'b1);
        do_reset(1'b0);
        send_frame(0, 0, 1'b0);
        send_frame(1, 0, 1'b0);     // error at pattern bit 192
        settle();
        check1("R5", "no lock: run restarted by search error", lock_prbs15_o, 1'b0);
        send_frame(0, 0, 1'b0);
        send_frame(0, 0, 1'b0);
        settle();
        check1("R5", "lock after a clean run follows the error", lock_prbs15_o, 1'b1);

        // R7: 30 errors at the end of one frame and 30 at the start of the next
        cur_tag = "R7";
        send_frame(0, 30, 1'b0);
        send_frame(30, 0, 1'b0);
        settle();
        check1("R7", "lock kept across split errors", lock_prbs15_o, 1'b1);

        // R8: long idle stretch with random data leaves the flags alone
        cur_tag = "R8";
        for (int i = 0; i < 300; i++) step(1'($urandom), 1'($urandom), 1'b0);
        settle();
        check1("R8", "lock unchanged over idle bits", lock_prbs15_o, 1'b1);
        check1("R8", "qrss unchanged over idle bits", lock_qrss_o, 1'b0);

        // R2 R3: E1 with the zero-limited sequence, slot 16 carries pattern
        cur_tag = "R2";
        do_reset(1'b1);
        sel = 1;
        repeat (3) send_frame(0, 0, 1'b1);
        settle();
        check1("R2", "qrss locked in E1", lock_qrss_o, 1'b1);
        check1("R3", "prbs15 unlocked on qrss stream", lock_prbs15_o, 1'b0);
        send_frame(32, 0, 1'b0);
        settle();
        check1("R6", "E1 qrss kept at 32 errors", lock_qrss_o, 1'b1);
        send_frame(0, 33, 1'b0);
        settle();
        check1("R6", "E1 qrss lost at 33 errors", lock_qrss_o, 1'b0);

        // R2: E1 with the 15-stage sequence
        do_reset(1'b1);
        sel = 0;
        repeat (2) send_frame(0, 0, 1'b0);
        settle();
        check1("R2", "prbs15 locked in E1", lock_prbs15_o, 1'b1);
        check1("R3", "qrss unlocked on prbs15 stream in E1", lock_qrss_o, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule